// File: doc/BRIEF.md
# User Interrupt Send Sequencer

This block carries out one send-user-interrupt command at a time. A command is a table index. The block first checks the execution preconditions and the index bound. It then reads a 16-byte entry from the target table through a simple request/acknowledge memory port and validates that entry. Next it reads the target's posted-interrupt descriptor with the bus lock held, sets the pending bit the entry selects, and writes the descriptor back. If the target is neither suppressing nor already notified, the block raises a single IPI request. The request carries the descriptor's notification vector and a destination whose format depends on the APIC addressing mode.

Each command ends with exactly one pulse. That pulse is either a success strobe or a fault strobe with a code. The fault codes are: 1 for invalid opcode and 2 for general protection.

Entry layout:
- bit 0: valid
- bits 7:1: must be zero
- bits 13:8: user vector
- bits 15:14: ignored
- bits 127:64: descriptor address

Descriptor layout:
- bit 0: outstanding
- bit 1: suppress
- bits 15:2 and 31:24: must be zero
- bits 23:16: notification vector
- bits 63:32: destination
- bits 127:64: pending bits

Top module: `uipi_sender`

## Requirements
- R1: If uint_en_i, tt_en_i and long_mode_i are not all 1, or if enclave_i is 1, the command ends with fault code 1 in the cycle after acceptance, and no memory request is made.
- R2: An index strictly greater than tt_size_i ends the command with fault code 2 and no memory request. An index equal to tt_size_i proceeds.
- R3: The entry is read, without the lock, at address tt_base_i + index*16.
- R4: An entry whose bit 0 is 0, or whose bits 7:1 are not all zero, ends the command with fault code 2, and the descriptor is never accessed.
- R5: The descriptor is read at entry bits 127:64 with mem_lock_o high. If descriptor bits 15:2 or 31:24 are nonzero, the command ends with fault code 2, no write is made, and the lock is dropped.
- R6: The written descriptor has pending bit 64+entry[13:8] set and all other pending bits unchanged; entry bits 15:14 have no effect.
- R7: When descriptor bits 1 (suppress) and 0 (outstanding) are both 0, bit 0 is written as 1 and one IPI is raised. Otherwise bit 0 is written back unchanged and no IPI is raised.
- R8: The write-back goes to the same address with mem_lock_o high, and the lock is low once the command completes.
- R9: The IPI vector is descriptor bits 23:16. With x2apic_i=1 the destination is descriptor bits 63:32. With x2apic_i=0 it is descriptor bits 47:40, zero-extended.
- R10: Every memory request is marked supervisor (mem_sup_o=1).
- R11: After reset the block is idle and ready. While a command is in flight, cmd_ready_o is low, and each command yields exactly one done_o or fault_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Idle; command accepted when valid and ready |
| cmd_idx_i | input | IDX_W | Target table index |
| busy_o | output | 1 | Command in flight |
| done_o | output | 1 | Success pulse |
| fault_o | output | 1 | Fault pulse |
| fault_code_o | output | 2 | 1 invalid opcode, 2 general protection |
| uint_en_i | input | 1 | User-interrupt enable |
| tt_en_i | input | 1 | Target table enable |
| long_mode_i | input | 1 | Core in 64-bit mode |
| enclave_i | input | 1 | Core inside an enclave |
| x2apic_i | input | 1 | Extended APIC addressing |
| tt_base_i | input | AW | Target table base address |
| tt_size_i | input | IDX_W | Highest valid index |
| mem_req_o | output | 1 | Memory request, held until ack |
| mem_we_o | output | 1 | Write request |
| mem_lock_o | output | 1 | Bus lock |
| mem_sup_o | output | 1 | Supervisor access |
| mem_addr_o | output | AW | Byte address |
| mem_wdata_o | output | 128 | Write data |
| mem_ack_i | input | 1 | Transfer complete |
| mem_rdata_i | input | 128 | Read data, valid with ack |
| ipi_valid_o | output | 1 | IPI request |
| ipi_ready_i | input | 1 | IPI accepted |
| ipi_vector_o | output | 8 | IPI vector |
| ipi_dest_o | output | 32 | IPI destination ID |

## Verification
The bench builds the block with IDX_W=8 and AW=64. The table size is set to 15 and the table base to zero, except in one relocated-base case, so entries and descriptors map into a 32-slot model memory. An index of 16 exercises the out-of-range fault. An index of 15 exercises the equal-to-size case. The byte width of IDX_W leaves headroom above the size, and the 64-bit address lets descriptor pointers and the base offset be checked on the full bus.

// File: rtl/uipi_pkg.sv
package uipi_pkg;
  localparam int unsigned LINE_W = 128;
  localparam int unsigned PEND_W = 64;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_UD   = 2'd1,
    FLT_GP   = 2'd2
  } flt_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ENT, ST_DESC, ST_WB, ST_IPI, ST_END
  } st_e;

  typedef struct packed {
    logic [63:0] daddr;
    logic [47:0] rsv_hi;
    logic [1:0]  uv_hi;
    logic [5:0]  uv;
    logic [6:0]  rsv_lo;
    logic        vld;
  } entry_t;

  typedef struct packed {
    logic [63:0] pend;
    logic [31:0] dest;
    logic [7:0]  rsv_hi;
    logic [7:0]  nv;
    logic [13:0] rsv_lo;
    logic        sn;
    logic        on;
  } desc_t;
endpackage

// File: rtl/uipi_entry_chk.sv
module uipi_entry_chk
  import uipi_pkg::*;
(
  input  logic [LINE_W-1:0] ent_i,
  output logic              ok_o,
  output logic [63:0]       daddr_o,
  output logic [5:0]        uv_o
);
  entry_t e;
  logic   unused_bits;

  assign e           = entry_t'(ent_i);
  assign ok_o        = e.vld && (e.rsv_lo == '0);
  assign daddr_o     = e.daddr;
  assign uv_o        = e.uv;
  assign unused_bits = ^{e.rsv_hi, e.uv_hi};
endmodule

// File: rtl/uipi_desc_upd.sv
module uipi_desc_upd
  import uipi_pkg::*;
#(
  parameter int unsigned NPEND = PEND_W,
  localparam int unsigned UV_W = $clog2(NPEND)
) (
  input  logic [LINE_W-1:0] desc_i,
  input  logic [UV_W-1:0]   uv_i,
  output logic              rsv_bad_o,
  output logic              notify_o,
  output logic [LINE_W-1:0] desc_o
);
  desc_t d_in, d_out;
  logic [NPEND-1:0] pend_new;

  assign d_in = desc_t'(desc_i);

  for (genvar g = 0; g < NPEND; g++) begin : g_pend
    assign pend_new[g] = d_in.pend[g] | (uv_i == UV_W'(g));
  end

  assign rsv_bad_o = (d_in.rsv_lo != '0) || (d_in.rsv_hi != '0);
  assign notify_o  = !d_in.sn && !d_in.on;

  always_comb begin
    d_out      = d_in;
    d_out.pend = pend_new;
    d_out.on   = d_in.on | notify_o;
  end

  assign desc_o = d_out;
endmodule

// File: rtl/uipi_ipi_fmt.sv
module uipi_ipi_fmt
  import uipi_pkg::*;
(
  input  logic [LINE_W-1:0] desc_i,
  input  logic              x2_i,
  output logic [7:0]        vec_o,
  output logic [31:0]       dest_o
);
  desc_t d;
  assign d      = desc_t'(desc_i);
  assign vec_o  = d.nv;
  // legacy mode: 8-bit id sits in bits 15:8 of the destination field
  assign dest_o = x2_i ? d.dest : {24'd0, d.dest[15:8]};
endmodule

// File: rtl/uipi_sender.sv
module uipi_sender
  import uipi_pkg::*;
#(
  parameter int unsigned IDX_W = 16,
  parameter int unsigned AW    = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [IDX_W-1:0]  cmd_idx_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic [1:0]        fault_code_o,
  input  logic              uint_en_i,
  input  logic              tt_en_i,
  input  logic              long_mode_i,
  input  logic              enclave_i,
  input  logic              x2apic_i,
  input  logic [AW-1:0]     tt_base_i,
  input  logic [IDX_W-1:0]  tt_size_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_lock_o,
  output logic              mem_sup_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [LINE_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [LINE_W-1:0] mem_rdata_i,
  output logic              ipi_valid_o,
  input  logic              ipi_ready_i,
  output logic [7:0]        ipi_vector_o,
  output logic [31:0]       ipi_dest_o
);
  localparam int unsigned ENT_SHIFT = $clog2(LINE_W / 8);
  localparam int unsigned UV_W      = $clog2(PEND_W);

  st_e               st_q;
  flt_e              flt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [AW-1:0]     base_q, daddr_q, ent_addr;
  logic [UV_W-1:0]   uv_q;
  logic [LINE_W-1:0] desc_q, desc_new;
  logic              x2_q, notify_q;
  logic              acc, ud_fail, idx_fail;
  logic              ent_ok, rsv_bad, notify;
  logic [63:0]       ent_daddr;
  logic [5:0]        ent_uv;

  assign acc      = cmd_valid_i && (st_q == ST_IDLE);
  assign ud_fail  = !(uint_en_i && tt_en_i && long_mode_i && !enclave_i);
  assign idx_fail = cmd_idx_i > tt_size_i;
  assign ent_addr = base_q + (AW'(idx_q) << ENT_SHIFT);

  uipi_entry_chk u_ent (
    .ent_i   (mem_rdata_i),
    .ok_o    (ent_ok),
    .daddr_o (ent_daddr),
    .uv_o    (ent_uv)
  );

  uipi_desc_upd #(.NPEND(PEND_W)) u_upd (
    .desc_i    (mem_rdata_i),
    .uv_i      (uv_q),
    .rsv_bad_o (rsv_bad),
    .notify_o  (notify),
    .desc_o    (desc_new)
  );

  uipi_ipi_fmt u_fmt (
    .desc_i (desc_q),
    .x2_i   (x2_q),
    .vec_o  (ipi_vector_o),
    .dest_o (ipi_dest_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      flt_q    <= FLT_NONE;
      idx_q    <= '0;
      base_q   <= '0;
      daddr_q  <= '0;
      uv_q     <= '0;
      desc_q   <= '0;
      x2_q     <= 1'b0;
      notify_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (acc) begin
          idx_q  <= cmd_idx_i;
          base_q <= tt_base_i;
          x2_q   <= x2apic_i;
          if (ud_fail) begin
            flt_q <= FLT_UD;
            st_q  <= ST_END;
          end else if (idx_fail) begin
            flt_q <= FLT_GP;
            st_q  <= ST_END;
          end else begin
            flt_q <= FLT_NONE;
            st_q  <= ST_ENT;
          end
        end
        ST_ENT: if (mem_ack_i) begin
          if (!ent_ok) begin
            flt_q <= FLT_GP;
            st_q  <= ST_END;
          end else begin
            daddr_q <= AW'(ent_daddr);
            uv_q    <= UV_W'(ent_uv);
            st_q    <= ST_DESC;
          end
        end
        ST_DESC: if (mem_ack_i) begin
          if (rsv_bad) begin
            flt_q <= FLT_GP;
            st_q  <= ST_END;
          end else begin
            desc_q   <= desc_new;
            notify_q <= notify;
            st_q     <= ST_WB;
          end
        end
        ST_WB:  if (mem_ack_i) st_q <= notify_q ? ST_IPI : ST_END;
        ST_IPI: if (ipi_ready_i) st_q <= ST_END;
        ST_END: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready_o  = (st_q == ST_IDLE);
  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = (st_q == ST_END) && (flt_q == FLT_NONE);
  assign fault_o      = (st_q == ST_END) && (flt_q != FLT_NONE);
  assign fault_code_o = fault_o ? flt_q : FLT_NONE;

  assign mem_req_o    = (st_q == ST_ENT) || (st_q == ST_DESC) || (st_q == ST_WB);
  assign mem_we_o     = (st_q == ST_WB);
  assign mem_lock_o   = (st_q == ST_DESC) || (st_q == ST_WB);
  assign mem_sup_o    = mem_req_o;
  assign mem_addr_o   = (st_q == ST_ENT) ? ent_addr : daddr_q;
  assign mem_wdata_o  = desc_q;
  assign ipi_valid_o  = (st_q == ST_IPI);

  // R1
  ud_no_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && ud_fail) |=> (fault_o && fault_code_o == FLT_UD && !mem_req_o));

  // R8
  wr_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> mem_lock_o);

  // R5
  lock_with_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_lock_o |-> mem_req_o);

  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  // R9
  ipi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ipi_valid_o && !ipi_ready_i) |=> (ipi_valid_o && $stable(ipi_dest_o) && $stable(ipi_vector_o)));

  // R11
  one_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |=> (!busy_o && !done_o && !fault_o));
endmodule

// File: tb/uipi_sender_test.sv
`timescale 1ns/1ps
module uipi_sender_test;
  localparam int unsigned IDX_W = 8;
  localparam int unsigned AW    = 64;

  typedef struct packed {
    logic        x2;
    logic [3:0]  idx;
    logic [15:0] ent;
    logic [63:0] dlo;
    logic [63:0] pend;
    logic [1:0]  code;
    logic [1:0]  rd;
    logic        wr;
    logic        ipi;
    logic [7:0]  vec;
    logic [31:0] dst;
  } row_t;

  localparam row_t TBL [9] = '{
    '{1'b1, 4'd1,  16'h0501, {32'hAABBCCDD, 8'h00, 8'h42, 16'h0000}, 64'h0,  2'd0, 2'd2, 1'b1, 1'b1, 8'h42, 32'hAABBCCDD},
    '{1'b0, 4'd2,  16'h4A01, {32'h12345678, 8'h00, 8'h77, 16'h0000}, 64'h1,  2'd0, 2'd2, 1'b1, 1'b1, 8'h77, 32'h00000056},
    '{1'b1, 4'd3,  16'h3F01, {32'h00000001, 8'h00, 8'h10, 16'h0001}, 64'h0,  2'd0, 2'd2, 1'b1, 1'b0, 8'h00, 32'h0},
    '{1'b0, 4'd4,  16'h0001, {32'h00000002, 8'h00, 8'h11, 16'h0002}, 64'h0,  2'd0, 2'd2, 1'b1, 1'b0, 8'h00, 32'h0},
    '{1'b1, 4'd5,  16'h0700, 64'h0,                                  64'h0,  2'd2, 2'd1, 1'b0, 1'b0, 8'h00, 32'h0},
    '{1'b1, 4'd6,  16'h0003, 64'h0,                                  64'h0,  2'd2, 2'd1, 1'b0, 1'b0, 8'h00, 32'h0},
    '{1'b1, 4'd7,  16'h0101, {32'h0, 8'h00, 8'h00, 16'h0004},        64'h0,  2'd2, 2'd2, 1'b0, 1'b0, 8'h00, 32'h0},
    '{1'b1, 4'd8,  16'h0101, {32'h0, 8'h01, 8'h00, 16'h0000},        64'h0,  2'd2, 2'd2, 1'b0, 1'b0, 8'h00, 32'h0},
    '{1'b0, 4'd15, 16'h0901, {32'h0000AB00, 8'h00, 8'h5A, 16'h0000}, 64'hFF, 2'd0, 2'd2, 1'b1, 1'b1, 8'h5A, 32'h000000AB}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             cmd_valid = 1'b0;
  logic             cmd_ready, busy, done, fault;
  logic [IDX_W-1:0] cmd_idx = '0;
  logic [1:0]       fcode;
  logic             uint_en = 1'b1, tt_en = 1'b1, long_mode = 1'b1, enclave = 1'b0, x2apic = 1'b0;
  logic [AW-1:0]    tt_base = '0;
  logic [IDX_W-1:0] tt_size = 8'd15;
  logic             mreq, mwe, mlock, msup;
  logic [AW-1:0]    maddr;
  logic [127:0]     mwdata, mrdata;
  logic             mack;
  logic             ipi_valid;
  logic [7:0]       ipi_vec;
  logic [31:0]      ipi_dst;

  uipi_sender #(.IDX_W(IDX_W), .AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_idx_i(cmd_idx),
    .busy_o(busy), .done_o(done), .fault_o(fault), .fault_code_o(fcode),
    .uint_en_i(uint_en), .tt_en_i(tt_en), .long_mode_i(long_mode), .enclave_i(enclave),
    .x2apic_i(x2apic), .tt_base_i(tt_base), .tt_size_i(tt_size),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_lock_o(mlock), .mem_sup_o(msup),
    .mem_addr_o(maddr), .mem_wdata_o(mwdata), .mem_ack_i(mack), .mem_rdata_i(mrdata),
    .ipi_valid_o(ipi_valid), .ipi_ready_i(1'b1), .ipi_vector_o(ipi_vec), .ipi_dest_o(ipi_dst)
  );

  // model memory: 32 lines of 16 bytes, loaded only by the stimulus process
  logic [127:0] mem_q [32];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mack   <= 1'b0;
      mrdata <= '0;
    end else begin
      mack   <= mreq && !mack;
      mrdata <= mem_q[maddr[8:4]];
    end
  end

  // monitor
  int unsigned rd_n = 0, wr_n = 0, pulse_n = 0, ipi_n = 0, nosup_n = 0;
  logic [AW-1:0] ent_addr_s = '0, wr_addr_s = '0, desc_addr_s = '0;
  logic          ent_lock_s = 1'b0, desc_lock_s = 1'b0, wr_lock_s = 1'b0;
  logic [127:0]  wr_data_s = '0;
  logic [7:0]    ipi_vec_s = '0;
  logic [31:0]   ipi_dst_s = '0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (mreq && !msup) nosup_n <= nosup_n + 1;
      if (mreq && mack) begin
        if (mwe) begin
          wr_n      <= wr_n + 1;
          wr_data_s <= mwdata;
          wr_lock_s <= mlock;
          wr_addr_s <= maddr;
        end else if (!mlock) begin
          rd_n       <= rd_n + 1;
          ent_addr_s <= maddr;
          ent_lock_s <= mlock;
        end else begin
          rd_n        <= rd_n + 1;
          desc_addr_s <= maddr;
          desc_lock_s <= mlock;
        end
      end
      if (done || fault) pulse_n <= pulse_n + 1;
      if (ipi_valid) begin
        ipi_n     <= ipi_n + 1;
        ipi_vec_s <= ipi_vec;
        ipi_dst_s <= ipi_dst;
      end
    end
  end

  int unsigned n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_desc(input logic [63:0] dlo, input logic [63:0] pend,
                                            input logic [15:0] ent);
    logic [63:0] p, lo;
    p  = pend | (64'd1 << ent[13:8]);
    lo = dlo;
    if (!dlo[1] && !dlo[0]) lo[0] = 1'b1;
    return {p, lo};
  endfunction

  int unsigned rd0, wr0, pl0, ip0;
  logic [1:0]  res_code;
  logic        ready_seen;

  task automatic do_cmd(input logic [IDX_W-1:0] idx);
    int unsigned t;
    rd0 = rd_n; wr0 = wr_n; pl0 = pulse_n; ip0 = ipi_n;
    ready_seen = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_idx   = idx;
    @(negedge clk);
    cmd_valid = 1'b0;
    t = 0;
    while (!(done || fault) && t < 100) begin
      if (cmd_ready) ready_seen = 1'b1;
      @(negedge clk);
      t++;
    end
    res_code = fault ? fcode : 2'd0;
    if (done && fault) res_code = 2'd3;
    @(negedge clk);
  endtask

  task automatic load_row(input row_t r);
    mem_q[r.idx]      = {64'h100 + (64'(r.idx) << 4), 48'h0, r.ent};
    mem_q[16 + r.idx] = {r.pend, r.dlo};
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mem_q[i] = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset ready", {127'd0, cmd_ready}, 128'd1);
    chk("R11 reset idle", {124'd0, busy, done, fault, mreq}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R4 R5 R6 R7 R8 R9 R11
    for (int i = 0; i < 9; i++) begin
      load_row(TBL[i]);
      x2apic = TBL[i].x2;
      do_cmd(IDX_W'(TBL[i].idx));
      chk("R4 R5 R7 code", 128'(res_code), 128'(TBL[i].code));
      chk("R4 R5 reads", 128'(rd_n - rd0), 128'(TBL[i].rd));
      chk("R5 R8 writes", 128'(wr_n - wr0), 128'(TBL[i].wr));
      chk("R7 ipi count", 128'(ipi_n - ip0), 128'(TBL[i].ipi));
      chk("R11 one pulse", 128'(pulse_n - pl0), 128'd1);
      chk("R11 ready low while busy", 128'(ready_seen), 128'd0);
      chk("R5 R8 lock released", 128'(mlock), 128'd0);
      if (TBL[i].rd == 2'd2) begin
        chk("R5 desc read locked", 128'(desc_lock_s), 128'd1);
        chk("R5 desc addr", 128'(desc_addr_s), 128'h100 + (128'(TBL[i].idx) << 4));
      end
      if (TBL[i].wr) begin
        chk("R6 R7 written desc", wr_data_s, exp_desc(TBL[i].dlo, TBL[i].pend, TBL[i].ent));
        chk("R8 write locked", 128'(wr_lock_s), 128'd1);
        chk("R8 write addr", 128'(wr_addr_s), 128'h100 + (128'(TBL[i].idx) << 4));
      end
      if (TBL[i].ipi) begin
        chk("R9 vector", 128'(ipi_vec_s), 128'(TBL[i].vec));
        chk("R9 dest", 128'(ipi_dst_s), 128'(TBL[i].dst));
      end
    end

    // R1 precondition faults
    for (int k = 0; k < 4; k++) begin
      uint_en = (k != 0); tt_en = (k != 1); long_mode = (k != 2); enclave = (k == 3);
      do_cmd(8'd1);
      chk("R1 ud code", 128'(res_code), 128'd1);
      chk("R1 no access", 128'(rd_n - rd0), 128'd0);
    end
    uint_en = 1'b1; tt_en = 1'b1; long_mode = 1'b1; enclave = 1'b0;

    // R2 index above size
    do_cmd(8'd16);
    chk("R2 gp code", 128'(res_code), 128'd2);
    chk("R2 no access", 128'(rd_n - rd0), 128'd0);

    // R3 relocated base: base 0x30, idx 2 -> 0x50
    tt_base = 64'h30;
    mem_q[5]  = {64'h1C0, 48'h0, 16'h0201};
    mem_q[28] = {64'h0, 32'h0, 8'h00, 8'h33, 16'h0002};
    do_cmd(8'd2);
    chk("R3 entry addr", 128'(ent_addr_s), 128'h50);
    chk("R3 entry unlocked", 128'(ent_lock_s), 128'd0);
    chk("R3 ok code", 128'(res_code), 128'd0);
    tt_base = '0;

    // R10
    chk("R10 supervisor", 128'(nosup_n), 128'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
    $finish;
  end
endmodule